// File: doc/BRIEF.md
# Exception Entry Sequencer

This block sits beside a processor's retire stage. It decides which pending event enters a handler: a synchronous exception, identified by a non-empty cause code, or a hardware interrupt. It then produces, in a single clock edge, every register value the core needs on entry. These are the new program counter, the saved status, the saved program counter, the saved stack pointer, the new status word, and the latched exception or interrupt cause.

The core raises `eval_req` in the cycle it wants one event evaluated. The interrupt controller receives the current mask level combinationally and answers combinationally with a vector, or reports that no vector is available. All results become visible on the outputs in the cycle after the evaluation edge, and `take_evt` marks that cycle. Side effects that live in the core, such as clearing the delay-slot flags and the halt-wake flag, are signalled by one-cycle pulses.

Status bit positions that the rest of the core decodes are fixed:
- bit 30 is the privileged mode bit;
- bit 29 is the register bank bit;
- bit 28 is the block bit;
- bit 15 is the FPU-disable bit;
- bits 7:4 are the interrupt mask.

Top module: `exc_entry_seq`

## Requirements
- R1: When `eval_req` is high and `exc_code` is not all ones, the exception is taken even if an interrupt is pending. In that case `intevt_out` keeps its value.
- R2: When the block bit (SR bit 28) is set, a pending exception with any code other than 0x1E0 is taken as code 0x000. Code 0x1E0 is taken unchanged.
- R3: When the block bit is set and only an interrupt is pending, nothing is taken unless `halt_wake` is high. `halt_wake_clr` pulses after any evaluation with the block bit set that gets past this gate.
- R4: `irq_mask_lvl` always equals SR bits 7:4. An interrupt for which `irq_vec_valid` is low is not taken.
- R5: On any taken event, `ssr_out` receives SR, `sgr_out` receives R15, and `sr_out` is SR with bits 30, 29 and 28 set.
- R6: If `ds_flag` or `ds_cond_flag` is high when an event is taken, `spc_out` is PC minus 2 and `ds_clr` pulses. Otherwise `spc_out` is PC.
- R7: Exception codes 0x000, 0x020 and 0x140 clear SR bit 15, force SR bits 7:4 to 0xF and set `pc_out` to 0xA0000000.
- R8: Exception codes 0x040 and 0x060 set `pc_out` to VBR+0x400. Every other exception code sets it to VBR+0x100. Code 0x160 additionally adds 2 to the saved PC.
- R9: A taken exception writes its code to `expevt_out`. A taken interrupt writes the vector to `intevt_out`, sets `pc_out` to VBR+0x600 and leaves `expevt_out` unchanged.
- R10: `take_evt` is high for exactly the one cycle that follows an evaluation edge at which an event was taken. All outputs change on that same edge.
- R11: With `eval_req` low, or with no event pending, all register outputs hold and no pulse is produced.
- R12: Reset sets `pc_out` to 0xA0000000, `sr_out` to 0x700000F0, and every other output register and pulse to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_req | input | 1 | Evaluate pending events this cycle |
| sr_in | input | 32 | Current status register |
| pc_in | input | 32 | Current program counter |
| r15_in | input | 32 | Current stack pointer register |
| vbr_in | input | 32 | Vector base |
| exc_code | input | 12 | Pending exception cause, all ones when none |
| irq_pending | input | 1 | Hardware interrupt request |
| irq_mask_lvl | output | 4 | Mask level sent to the interrupt controller |
| irq_vec_valid | input | 1 | Controller has a vector above the mask |
| irq_vec | input | 12 | Interrupt vector from the controller |
| ds_flag | input | 1 | Current instruction sits in a delay slot |
| ds_cond_flag | input | 1 | Current instruction sits in a conditional delay slot |
| halt_wake | input | 1 | Core was halted and may be woken |
| pc_out | output | 32 | Handler entry address |
| ssr_out | output | 32 | Saved status |
| spc_out | output | 32 | Saved program counter |
| sgr_out | output | 32 | Saved stack pointer |
| sr_out | output | 32 | Status on entry |
| expevt_out | output | 12 | Latched exception cause |
| intevt_out | output | 12 | Latched interrupt vector |
| take_evt | output | 1 | One-cycle strobe: an event was entered |
| ds_clr | output | 1 | One-cycle request to clear the delay-slot flags |
| halt_wake_clr | output | 1 | One-cycle request to clear the halt-wake flag |

## Verification
Stimulus pairs a pending exception with a live interrupt to show the priority. It then toggles the block bit and the wake flag, so that reset substitution, the 0x1E0 exemption, a sleeping interrupt and a woken interrupt each produce a different outcome.

Codes from every handler class are applied, with and without delay-slot flags. This separates the reset-class, TLB-class and general offsets, and shows how the delay-slot rewind combines with the trap advance.

Idle requests, requests with nothing pending, and interrupts without a vector confirm that the outputs hold. Back-to-back requests show that the strobe falls when the second request takes nothing.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN      = 32;
    localparam int CODE_W    = 12;
    localparam int IMASK_W   = 4;

    // Status word bit positions decoded elsewhere in the core
    localparam int SR_MD_BIT    = 30;
    localparam int SR_RB_BIT    = 29;
    localparam int SR_BL_BIT    = 28;
    localparam int SR_FD_BIT    = 15;
    localparam int SR_IMASK_LO  = 4;

    localparam logic [CODE_W-1:0] CODE_NONE      = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_POWER     = 12'h000;
    localparam logic [CODE_W-1:0] CODE_MANUAL    = 12'h020;
    localparam logic [CODE_W-1:0] CODE_MULTIHIT  = 12'h140;
    localparam logic [CODE_W-1:0] CODE_TLB_RD    = 12'h040;
    localparam logic [CODE_W-1:0] CODE_TLB_WR    = 12'h060;
    localparam logic [CODE_W-1:0] CODE_TRAP      = 12'h160;
    localparam logic [CODE_W-1:0] CODE_BL_EXEMPT = 12'h1E0;

    localparam logic [XLEN-1:0] RESET_PC   = 32'hA000_0000;
    localparam logic [XLEN-1:0] OFS_GEN    = 32'h0000_0100;
    localparam logic [XLEN-1:0] OFS_TLB    = 32'h0000_0400;
    localparam logic [XLEN-1:0] OFS_IRQ    = 32'h0000_0600;
    localparam logic [XLEN-1:0] INSN_BYTES = 32'd2;

    localparam logic [XLEN-1:0] SR_RESET_VAL = 32'h7000_00F0;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_EXC  = 2'd1,
        EV_IRQ  = 2'd2
    } ev_kind_e;

    typedef enum logic [1:0] {
        HC_RESET = 2'd0,
        HC_TLB   = 2'd1,
        HC_GEN   = 2'd2
    } hclass_e;

    typedef struct packed {
        ev_kind_e            kind;
        logic [CODE_W-1:0]   code;
        logic                wake_clr;
    } decision_t;

    typedef struct packed {
        ev_kind_e            kind;
        logic [CODE_W-1:0]   code;
        logic [XLEN-1:0]     pc;
        logic [XLEN-1:0]     ssr;
        logic [XLEN-1:0]     spc;
        logic [XLEN-1:0]     sgr;
        logic [XLEN-1:0]     sr;
        logic                ds_clr;
        logic                wake_clr;
    } entry_t;

    function automatic hclass_e handler_class(input logic [CODE_W-1:0] c);
        if (c == CODE_POWER || c == CODE_MANUAL || c == CODE_MULTIHIT)
            return HC_RESET;
        else if (c == CODE_TLB_RD || c == CODE_TLB_WR)
            return HC_TLB;
        else
            return HC_GEN;
    endfunction

    function automatic logic [XLEN-1:0] entry_sr(input logic [XLEN-1:0] sr);
        logic [XLEN-1:0] r;
        r = sr;
        r[SR_MD_BIT] = 1'b1;
        r[SR_RB_BIT] = 1'b1;
        r[SR_BL_BIT] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_entry_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          req,
    input  logic [CW-1:0] exc_code,
    input  logic          blocked,
    input  logic          irq_pending,
    input  logic          irq_vec_valid,
    input  logic [CW-1:0] irq_vec,
    input  logic          halt_wake,
    output decision_t     decision
);
    localparam logic [CW-1:0] NONE = {CW{1'b1}};

    logic exc_live;
    logic irq_gate_open;

    assign exc_live      = (exc_code != NONE);
    assign irq_gate_open = !blocked || halt_wake;

    always_comb begin
        decision.kind     = EV_NONE;
        decision.code     = '0;
        decision.wake_clr = 1'b0;
        if (req) begin
            if (exc_live) begin
                decision.kind     = EV_EXC;
                decision.code     = (blocked && exc_code != CODE_BL_EXEMPT)
                                    ? CODE_POWER : exc_code;
                decision.wake_clr = blocked;
            end else if (irq_pending && irq_gate_open) begin
                decision.wake_clr = blocked;
                if (irq_vec_valid) begin
                    decision.kind = EV_IRQ;
                    decision.code = irq_vec;
                end
            end
        end
    end
endmodule

// File: rtl/exc_target_gen.sv
module exc_target_gen
    import exc_entry_pkg::*;
#(
    parameter int W = XLEN
) (
    input  decision_t    decision,
    input  logic [W-1:0] sr_in,
    input  logic [W-1:0] pc_in,
    input  logic [W-1:0] r15_in,
    input  logic [W-1:0] vbr_in,
    input  logic         ds_flag,
    input  logic         ds_cond_flag,
    output entry_t       entry
);
    logic    in_slot;
    logic    is_exc;
    logic    is_trap;
    hclass_e hc;

    assign in_slot = ds_flag || ds_cond_flag;
    assign is_exc  = (decision.kind == EV_EXC);
    assign is_trap = is_exc && (decision.code == CODE_TRAP);
    assign hc      = handler_class(decision.code);

    always_comb begin
        logic [W-1:0] spc_v;
        logic [W-1:0] sr_v;

        spc_v = pc_in;
        if (in_slot)
            spc_v = spc_v - INSN_BYTES;
        if (is_trap)
            spc_v = spc_v + INSN_BYTES;

        sr_v = entry_sr(sr_in);
        if (is_exc && hc == HC_RESET) begin
            sr_v[SR_FD_BIT] = 1'b0;
            sr_v[SR_IMASK_LO +: IMASK_W] = {IMASK_W{1'b1}};
        end

        entry.kind     = decision.kind;
        entry.code     = decision.code;
        entry.ssr      = sr_in;
        entry.sgr      = r15_in;
        entry.spc      = spc_v;
        entry.sr       = sr_v;
        entry.ds_clr   = in_slot && (decision.kind != EV_NONE);
        entry.wake_clr = decision.wake_clr;

        unique case (decision.kind)
            EV_EXC: begin
                unique case (hc)
                    HC_RESET: entry.pc = RESET_PC;
                    HC_TLB:   entry.pc = vbr_in + OFS_TLB;
                    default:  entry.pc = vbr_in + OFS_GEN;
                endcase
            end
            EV_IRQ:  entry.pc = vbr_in + OFS_IRQ;
            default: entry.pc = pc_in;
        endcase
    end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
    import exc_entry_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  entry_t        entry,
    output logic [W-1:0]  pc_q,
    output logic [W-1:0]  ssr_q,
    output logic [W-1:0]  spc_q,
    output logic [W-1:0]  sgr_q,
    output logic [W-1:0]  sr_q,
    output logic [CW-1:0] expevt_q,
    output logic [CW-1:0] intevt_q,
    output logic          take_q,
    output logic          ds_clr_q,
    output logic          wake_clr_q
);
    logic taking;
    assign taking = (entry.kind != EV_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q       <= RESET_PC;
            ssr_q      <= '0;
            spc_q      <= '0;
            sgr_q      <= '0;
            sr_q       <= SR_RESET_VAL;
            expevt_q   <= '0;
            intevt_q   <= '0;
            take_q     <= 1'b0;
            ds_clr_q   <= 1'b0;
            wake_clr_q <= 1'b0;
        end else begin
            take_q     <= taking;
            ds_clr_q   <= entry.ds_clr;
            wake_clr_q <= entry.wake_clr;
            if (taking) begin
                pc_q  <= entry.pc;
                ssr_q <= entry.ssr;
                spc_q <= entry.spc;
                sgr_q <= entry.sgr;
                sr_q  <= entry.sr;
            end
            if (entry.kind == EV_EXC)
                expevt_q <= entry.code;
            if (entry.kind == EV_IRQ)
                intevt_q <= entry.code;
        end
    end

    AST_DS_CLR_WITH_TAKE: assert property (@(posedge clk) disable iff (rst)
        ds_clr_q |-> take_q);  // R6
    AST_ENTRY_SR_BITS: assert property (@(posedge clk) disable iff (rst)
        take_q |-> (sr_q[SR_BL_BIT] && sr_q[SR_MD_BIT] && sr_q[SR_RB_BIT]));  // R5
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int CW = CODE_W,
    parameter int MW = IMASK_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          eval_req,
    input  logic [W-1:0]  sr_in,
    input  logic [W-1:0]  pc_in,
    input  logic [W-1:0]  r15_in,
    input  logic [W-1:0]  vbr_in,
    input  logic [CW-1:0] exc_code,
    input  logic          irq_pending,
    output logic [MW-1:0] irq_mask_lvl,
    input  logic          irq_vec_valid,
    input  logic [CW-1:0] irq_vec,
    input  logic          ds_flag,
    input  logic          ds_cond_flag,
    input  logic          halt_wake,
    output logic [W-1:0]  pc_out,
    output logic [W-1:0]  ssr_out,
    output logic [W-1:0]  spc_out,
    output logic [W-1:0]  sgr_out,
    output logic [W-1:0]  sr_out,
    output logic [CW-1:0] expevt_out,
    output logic [CW-1:0] intevt_out,
    output logic          take_evt,
    output logic          ds_clr,
    output logic          halt_wake_clr
);
    decision_t decision;
    entry_t    entry;

    assign irq_mask_lvl = sr_in[SR_IMASK_LO +: MW];

    exc_arbiter #(.CW(CW)) u_arb (
        .req           (eval_req),
        .exc_code      (exc_code),
        .blocked       (sr_in[SR_BL_BIT]),
        .irq_pending   (irq_pending),
        .irq_vec_valid (irq_vec_valid),
        .irq_vec       (irq_vec),
        .halt_wake     (halt_wake),
        .decision      (decision)
    );

    exc_target_gen #(.W(W)) u_tgt (
        .decision     (decision),
        .sr_in        (sr_in),
        .pc_in        (pc_in),
        .r15_in       (r15_in),
        .vbr_in       (vbr_in),
        .ds_flag      (ds_flag),
        .ds_cond_flag (ds_cond_flag),
        .entry        (entry)
    );

    exc_state_regs #(.W(W), .CW(CW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .entry      (entry),
        .pc_q       (pc_out),
        .ssr_q      (ssr_out),
        .spc_q      (spc_out),
        .sgr_q      (sgr_out),
        .sr_q       (sr_out),
        .expevt_q   (expevt_out),
        .intevt_q   (intevt_out),
        .take_q     (take_evt),
        .ds_clr_q   (ds_clr),
        .wake_clr_q (halt_wake_clr)
    );

    logic exc_live;
    assign exc_live = (exc_code != {CW{1'b1}});

    AST_EXC_BEATS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (eval_req && exc_live) |=> (take_evt && $stable(intevt_out)));  // R1
    AST_BL_TO_RESET: assert property (@(posedge clk) disable iff (rst)
        (eval_req && exc_live && sr_in[SR_BL_BIT] && exc_code != CODE_BL_EXEMPT)
        |=> (expevt_out == CODE_POWER && pc_out == RESET_PC));  // R2
    AST_BL_IRQ_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        (eval_req && !exc_live && sr_in[SR_BL_BIT] && !halt_wake) |=> !take_evt);  // R3
    AST_NO_VEC_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        (eval_req && !exc_live && !irq_vec_valid) |=> !take_evt);  // R4
    AST_SAVE_CONTEXT: assert property (@(posedge clk) disable iff (rst)
        take_evt |-> (ssr_out == $past(sr_in) && sgr_out == $past(r15_in)));  // R5
    AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (eval_req && !exc_live && irq_pending && irq_vec_valid
         && (!sr_in[SR_BL_BIT] || halt_wake))
        |=> (intevt_out == $past(irq_vec) && pc_out == $past(vbr_in) + OFS_IRQ));  // R9
    AST_STROBE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        take_evt |-> $past(eval_req));  // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !eval_req |=> (!take_evt && $stable(pc_out) && $stable(sr_out)
                       && $stable(spc_out) && !halt_wake_clr));  // R11
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        eval_req = 1'b0;
    logic [31:0] sr_in = '0, pc_in = '0, r15_in = '0, vbr_in = '0;
    logic [11:0] exc_code = 12'hFFF;
    logic        irq_pending = 1'b0;
    logic [3:0]  irq_mask_lvl;
    logic        irq_vec_valid = 1'b0;
    logic [11:0] irq_vec = '0;
    logic        ds_flag = 1'b0, ds_cond_flag = 1'b0, halt_wake = 1'b0;
    logic [31:0] pc_out, ssr_out, spc_out, sgr_out, sr_out;
    logic [11:0] expevt_out, intevt_out;
    logic        take_evt, ds_clr, halt_wake_clr;

    always #10 clk = ~clk;

    exc_entry_seq u_dut (
        .clk(clk), .rst(rst), .eval_req(eval_req), .sr_in(sr_in), .pc_in(pc_in),
        .r15_in(r15_in), .vbr_in(vbr_in), .exc_code(exc_code),
        .irq_pending(irq_pending), .irq_mask_lvl(irq_mask_lvl),
        .irq_vec_valid(irq_vec_valid), .irq_vec(irq_vec), .ds_flag(ds_flag),
        .ds_cond_flag(ds_cond_flag), .halt_wake(halt_wake), .pc_out(pc_out),
        .ssr_out(ssr_out), .spc_out(spc_out), .sgr_out(sgr_out), .sr_out(sr_out),
        .expevt_out(expevt_out), .intevt_out(intevt_out), .take_evt(take_evt),
        .ds_clr(ds_clr), .halt_wake_clr(halt_wake_clr)
    );

    typedef struct {
        logic        req;
        logic [31:0] sr, pc, r15, vbr;
        logic [11:0] code;
        logic        irqp, vv;
        logic [11:0] vec;
        logic        ds, dsc, wake;
    } stim_t;

    typedef struct {
        string       tag;
        int          due;
        logic [31:0] pc, ssr, spc, sgr, sr;
        logic [11:0] expevt, intevt;
        logic        take, dsclr, wclr;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // Reference state, built from the requirements
    logic [31:0] m_pc = 32'hA000_0000, m_ssr = '0, m_spc = '0, m_sgr = '0;
    logic [31:0] m_sr = 32'h7000_00F0;
    logic [11:0] m_expevt = '0, m_intevt = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic stim_t idle();
        stim_t s;
        s.req = 1'b1; s.sr = 32'h0000_0010; s.pc = 32'h0C00_1000;
        s.r15 = 32'h0CFF_FFF0; s.vbr = 32'h8C00_0000; s.code = 12'hFFF;
        s.irqp = 1'b0; s.vv = 1'b0; s.vec = 12'h000;
        s.ds = 1'b0; s.dsc = 1'b0; s.wake = 1'b0;
        return s;
    endfunction

    task automatic run(input string tag, input stim_t s);
        exp_t e;
        int   kind;
        logic bl;
        logic [11:0] eff;
        logic [31:0] nsr, nspc;
        @(negedge clk);
        eval_req = s.req; sr_in = s.sr; pc_in = s.pc; r15_in = s.r15;
        vbr_in = s.vbr; exc_code = s.code; irq_pending = s.irqp;
        irq_vec_valid = s.vv; irq_vec = s.vec; ds_flag = s.ds;
        ds_cond_flag = s.dsc; halt_wake = s.wake;

        kind = 0; eff = s.code; bl = s.sr[28];
        e.wclr = 1'b0;
        if (s.req) begin
            if (s.code != 12'hFFF) begin
                kind = 1;                                     // R1
                eff = (bl && s.code != 12'h1E0) ? 12'h000 : s.code;  // R2
                e.wclr = bl;
            end else if (s.irqp && (!bl || s.wake)) begin     // R3
                e.wclr = bl;
                if (s.vv) begin kind = 2; eff = s.vec; end    // R4
            end
        end
        if (kind != 0) begin
            m_ssr = s.sr; m_sgr = s.r15;                      // R5
            nspc = s.pc;
            if (s.ds || s.dsc) nspc = nspc - 32'd2;           // R6
            if (kind == 1 && eff == 12'h160) nspc = nspc + 32'd2;  // R8
            m_spc = nspc;
            nsr = s.sr | 32'h7000_0000;
            if (kind == 1 && (eff == 12'h000 || eff == 12'h020 || eff == 12'h140)) begin
                nsr = (nsr & ~32'h0000_80F0) | 32'h0000_00F0;   // R7
                m_pc = 32'hA000_0000;
            end else if (kind == 1 && (eff == 12'h040 || eff == 12'h060))
                m_pc = s.vbr + 32'h400;
            else if (kind == 1)
                m_pc = s.vbr + 32'h100;
            else
                m_pc = s.vbr + 32'h600;                       // R9
            m_sr = nsr;
            if (kind == 1) m_expevt = eff; else m_intevt = eff;
        end
        e.tag = tag; e.due = cyc + 1;
        e.pc = m_pc; e.ssr = m_ssr; e.spc = m_spc; e.sgr = m_sgr; e.sr = m_sr;
        e.expevt = m_expevt; e.intevt = m_intevt;
        e.take = (kind != 0);                                 // R10
        e.dsclr = (kind != 0) && (s.ds || s.dsc);
        q.push_back(e);

        #1;
        n_tests++;
        if (irq_mask_lvl !== s.sr[7:4]) begin
            n_fail++;
            $display("FAIL R4 mask level: actual %h expected %h", irq_mask_lvl, s.sr[7:4]);
        end
    endtask

    // Monitor: pops expected items once their result cycle is reached
    always @(negedge clk) begin
        if (!rst && q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_tests++;
            if (pc_out !== e.pc || ssr_out !== e.ssr || spc_out !== e.spc ||
                sgr_out !== e.sgr || sr_out !== e.sr || expevt_out !== e.expevt ||
                intevt_out !== e.intevt || take_evt !== e.take ||
                ds_clr !== e.dsclr || halt_wake_clr !== e.wclr) begin
                n_fail++;
                $display("FAIL %s: actual pc=%h ssr=%h spc=%h sgr=%h sr=%h exp=%h int=%h tk=%b ds=%b wk=%b expected pc=%h ssr=%h spc=%h sgr=%h sr=%h exp=%h int=%h tk=%b ds=%b wk=%b",
                    e.tag, pc_out, ssr_out, spc_out, sgr_out, sr_out, expevt_out,
                    intevt_out, take_evt, ds_clr, halt_wake_clr, e.pc, e.ssr, e.spc,
                    e.sgr, e.sr, e.expevt, e.intevt, e.take, e.dsclr, e.wclr);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        stim_t s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_tests++;  // R12 reset state
        if (pc_out !== 32'hA000_0000 || sr_out !== 32'h7000_00F0 || ssr_out !== 0 ||
            spc_out !== 0 || sgr_out !== 0 || expevt_out !== 0 || intevt_out !== 0 ||
            take_evt !== 0 || ds_clr !== 0 || halt_wake_clr !== 0) begin
            n_fail++;
            $display("FAIL R12 reset: actual pc=%h sr=%h tk=%b expected pc=a0000000 sr=700000f0 tk=0",
                     pc_out, sr_out, take_evt);
        end

        s = idle(); s.code = 12'h180; s.irqp = 1; s.vv = 1; s.vec = 12'h3C0;
        run("R1", s);
        s = idle(); s.irqp = 1; s.vv = 1; s.vec = 12'h3C0; s.sr = 32'h4000_00A0;
        run("R9", s);
        s = idle(); s.irqp = 1; s.vv = 0; s.sr = 32'h0000_00A0;
        run("R4", s);
        s = idle(); s.sr = 32'h1000_8030; s.code = 12'h0A0;
        run("R2", s);
        s = idle(); s.sr = 32'h1000_0000; s.code = 12'h1E0; s.vbr = 32'h8000_1000;
        run("R2", s);
        s = idle(); s.sr = 32'h1000_0000; s.irqp = 1; s.vv = 1; s.vec = 12'h200;
        run("R3", s);
        s = idle(); s.sr = 32'h1000_0000; s.irqp = 1; s.vv = 1; s.vec = 12'h220; s.wake = 1;
        run("R3", s);
        s = idle(); s.sr = 32'h0123_4560; s.r15 = 32'hDEAD_BEE0; s.code = 12'h180;
        run("R5", s);
        s = idle(); s.code = 12'h180; s.ds = 1; s.pc = 32'h0C00_2004;
        run("R6", s);
        s = idle(); s.irqp = 1; s.vv = 1; s.vec = 12'h240; s.dsc = 1; s.pc = 32'h0C00_3008;
        run("R6", s);
        s = idle(); s.code = 12'h020; s.sr = 32'h0000_8030;
        run("R7", s);
        s = idle(); s.code = 12'h140; s.sr = 32'h0000_8000;
        run("R7", s);
        s = idle(); s.code = 12'h040;
        run("R8", s);
        s = idle(); s.code = 12'h060; s.vbr = 32'h8C10_0000;
        run("R8", s);
        s = idle(); s.code = 12'h160; s.pc = 32'h0C00_4000;
        run("R8", s);
        s = idle(); s.code = 12'h160; s.ds = 1; s.pc = 32'h0C00_5000;
        run("R8", s);
        s = idle();
        run("R11", s);
        s = idle(); s.req = 0; s.code = 12'h180; s.irqp = 1; s.vv = 1;
        run("R11", s);
        s = idle(); s.code = 12'h0E0;
        run("R10", s);
        s = idle();
        run("R10", s);
        s = idle(); s.req = 0;
        run("R11", s);

        while (q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule